// File: doc/BRIEF.md
# Descriptor-driven memory DMA channel

A single DMA channel that moves data between locations of a word-wide memory under the control of descriptors. Software-side logic pushes descriptors into a small internal queue. The channel takes them out one at a time, in the order they were pushed, and carries each one out to the end before it starts the next. Each descriptor carries an opcode, a source word address, a destination word address, a length in 64-bit words, a 64-bit fill pattern, an interrupt-enable flag and a fence flag.

A copy reads one source word and writes it to the destination on the following cycle, then moves on to the next word. A fill writes the pattern to one destination word per cycle. A null descriptor touches no memory but still completes. Writes are posted: the memory acknowledges each one later on a separate strobe. The channel counts the writes that have not yet been acknowledged. A fenced descriptor waits until that count is zero, so its reads cannot see stale data. An unfenced descriptor may start reading while earlier writes are still in flight. Every descriptor ends with a one-cycle completion pulse. The pulse carries a running descriptor index, an error bit and the descriptor's interrupt-enable flag.

Top module: `dma_channel`

## Requirements
- R1: After reset, `mem_rd_o`, `mem_wr_o` and `done_o` are low and `dsc_ready_o` is high.
- R2: Descriptors complete strictly in push order, one at a time. `done_idx_o` is 0 on the first completion after reset and increases by one on each later completion.
- R3: A copy (opcode 1) of length N, for i = 0..N-1, asserts `mem_rd_o` at address src+i. On the next cycle it asserts `mem_wr_o` at address dst+i, with `mem_wdata_o` equal to the `mem_rdata_i` presented in that cycle. Memory returns read data in the cycle after `mem_rd_o`.
- R4: A fill (opcode 2) of length N writes the 64-bit pattern to addresses dst..dst+N-1, in ascending order, one word per cycle.
- R5: A null (opcode 0) descriptor makes no memory access and completes with error 0.
- R6: A copy or fill of length 0 makes no memory access and completes with error 0.
- R7: A descriptor whose length exceeds MAX_WORDS (default 131072 words, i.e. 1 MiB) makes no memory access and completes with error 1.
- R8: Opcode 3 is reserved. Such a descriptor makes no memory access and completes with error 1.
- R9: `done_o` is high for exactly one cycle per descriptor, and `done_irq_o` equals that descriptor's interrupt-enable flag.
- R10: A fenced descriptor makes no memory access and does not complete until every earlier write has been acknowledged on `mem_wack_i`.
- R11: Without a fence, a copy may issue its first read while writes of earlier descriptors are still unacknowledged.
- R12: The queue holds up to DEPTH descriptors (default 4) while the channel is busy. `dsc_ready_o` is low when the queue is full, and a push is taken only when `dsc_valid_i` and `dsc_ready_o` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dsc_valid_i | input | 1 | Descriptor push request |
| dsc_ready_o | output | 1 | Queue has room |
| dsc_op_i | input | 2 | Opcode: 0 null, 1 copy, 2 fill, 3 reserved |
| dsc_src_i | input | AW | Source word address |
| dsc_dst_i | input | AW | Destination word address |
| dsc_len_i | input | LW | Length in words |
| dsc_pat_i | input | 64 | Fill pattern |
| dsc_irq_i | input | 1 | Interrupt enable for this descriptor |
| dsc_fence_i | input | 1 | Wait for earlier writes to drain before starting |
| mem_rd_o | output | 1 | Read strobe |
| mem_raddr_o | output | AW | Read word address |
| mem_rdata_i | input | 64 | Read data, valid the cycle after the strobe |
| mem_wr_o | output | 1 | Write strobe (posted) |
| mem_waddr_o | output | AW | Write word address |
| mem_wdata_o | output | 64 | Write data |
| mem_wack_i | input | 1 | One pulse per write when it has finished |
| done_o | output | 1 | Completion pulse |
| done_idx_o | output | IW | Index of the completed descriptor |
| done_err_o | output | 1 | Descriptor rejected |
| done_irq_o | output | 1 | Interrupt enable of the completed descriptor |

## Verification
The assertions assume three things about the memory side. It returns one acknowledge per write, never more acknowledges than writes issued, and read data exactly one cycle after the strobe. They also assume that no push happens while the queue is full. The bench's memory responder acknowledges every write exactly once after a fixed delay that is longer than the gap between descriptors, so the unfenced overlap case really does occur. The bench pushes only while `dsc_ready_o` is high. Addresses stay inside a 256-word window that the responder models in full.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned DW = 64;

  typedef enum logic [1:0] {
    OP_NULL = 2'd0,
    OP_COPY = 2'd1,
    OP_FILL = 2'd2,
    OP_RSVD = 2'd3
  } dma_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FENCE, S_DISP, S_RD, S_WR, S_CMPL
  } dma_state_e;
endpackage

// File: rtl/dma_desc_fifo.sv
module dma_desc_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             full_o,
  input  logic             pop_i,
  output logic             empty_o,
  output logic [WIDTH-1:0] data_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign data_o  = mem_q[rd_ptr_q];

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= data_i;
  end

  assert_no_overflow_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  assert_no_underflow_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
endmodule

// File: rtl/dma_wr_tracker.sv
module dma_wr_tracker #(
  parameter int unsigned CW = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic ack_i,
  output logic idle_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CW'(wr_i) - CW'(ack_i);
  end

  assign idle_o = (cnt_q == '0);

  // acks must never outnumber issued writes
  assert_ack_has_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> (!idle_o || wr_i));
  assert_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_q) |-> !(wr_i && !ack_i));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned LW        = 21,
  parameter int unsigned IW        = 8,
  parameter int unsigned MAX_WORDS = 131072
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dsc_avail_i,
  output logic          dsc_pop_o,
  input  dma_op_e       dsc_op_i,
  input  logic [AW-1:0] dsc_src_i,
  input  logic [AW-1:0] dsc_dst_i,
  input  logic [LW-1:0] dsc_len_i,
  input  logic [DW-1:0] dsc_pat_i,
  input  logic          dsc_irq_i,
  input  logic          dsc_fence_i,
  input  logic          wr_idle_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_raddr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          done_o,
  output logic [IW-1:0] done_idx_o,
  output logic          done_err_o,
  output logic          done_irq_o
);
  localparam logic [LW:0] MAX_LEN = (LW+1)'(MAX_WORDS);

  dma_state_e    state_q;
  dma_op_e       op_q;
  logic [AW-1:0] src_q, dst_q;
  logic [LW-1:0] rem_q;
  logic [DW-1:0] pat_q;
  logic          irq_q, fence_q, err_q;
  logic [IW-1:0] idx_q;
  logic          len_bad;

  assign len_bad   = ({1'b0, rem_q} > MAX_LEN) || (op_q == OP_RSVD);
  assign dsc_pop_o = (state_q == S_IDLE) && dsc_avail_i;

  assign mem_rd_o    = (state_q == S_RD);
  assign mem_raddr_o = src_q;
  assign mem_wr_o    = (state_q == S_WR);
  assign mem_waddr_o = dst_q;
  assign mem_wdata_o = (op_q == OP_COPY) ? mem_rdata_i : pat_q;

  assign done_o     = (state_q == S_CMPL);
  assign done_idx_o = idx_q;
  assign done_err_o = err_q;
  assign done_irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_NULL;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      pat_q   <= '0;
      irq_q   <= 1'b0;
      fence_q <= 1'b0;
      err_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (dsc_avail_i) begin
          op_q    <= dsc_op_i;
          src_q   <= dsc_src_i;
          dst_q   <= dsc_dst_i;
          rem_q   <= dsc_len_i;
          pat_q   <= dsc_pat_i;
          irq_q   <= dsc_irq_i;
          fence_q <= dsc_fence_i;
          err_q   <= 1'b0;
          state_q <= dsc_fence_i ? S_FENCE : S_DISP;
        end
        S_FENCE: if (wr_idle_i) state_q <= S_DISP;
        S_DISP: begin
          if (len_bad) begin
            err_q   <= 1'b1;
            state_q <= S_CMPL;
          end else if (op_q == OP_NULL || rem_q == '0) begin
            state_q <= S_CMPL;
          end else begin
            state_q <= (op_q == OP_COPY) ? S_RD : S_WR;
          end
        end
        S_RD: begin
          src_q   <= src_q + 1'b1;
          state_q <= S_WR;
        end
        S_WR: begin
          dst_q <= dst_q + 1'b1;
          rem_q <= rem_q - 1'b1;
          if (rem_q == LW'(1))        state_q <= S_CMPL;
          else if (op_q == OP_COPY)   state_q <= S_RD;
        end
        S_CMPL: begin
          idx_q   <= idx_q + 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_fence_drained_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DISP && fence_q) |-> wr_idle_i);
  assert_rd_then_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> mem_wr_o);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_no_access_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DISP && len_bad) |=> (!mem_rd_o && !mem_wr_o && done_o && done_err_o));
  assert_idx_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_idx_o == $past(done_idx_o) + 1'b1));
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned LW        = 21,
  parameter int unsigned IW        = 8,
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned OUT_W     = 8,
  parameter int unsigned MAX_WORDS = 131072
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dsc_valid_i,
  output logic          dsc_ready_o,
  input  logic [1:0]    dsc_op_i,
  input  logic [AW-1:0] dsc_src_i,
  input  logic [AW-1:0] dsc_dst_i,
  input  logic [LW-1:0] dsc_len_i,
  input  logic [63:0]   dsc_pat_i,
  input  logic          dsc_irq_i,
  input  logic          dsc_fence_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_raddr_o,
  input  logic [63:0]   mem_rdata_i,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [63:0]   mem_wdata_o,
  input  logic          mem_wack_i,
  output logic          done_o,
  output logic [IW-1:0] done_idx_o,
  output logic          done_err_o,
  output logic          done_irq_o
);
  localparam int unsigned DSC_W = 2 + 2*AW + LW + DW + 2;

  logic [DSC_W-1:0] push_data, head;
  logic             full, empty, pop, wr_idle;
  logic [1:0]       h_op;
  logic [AW-1:0]    h_src, h_dst;
  logic [LW-1:0]    h_len;
  logic [DW-1:0]    h_pat;
  logic             h_irq, h_fence;

  assign dsc_ready_o = !full;
  assign push_data   = {dsc_op_i, dsc_src_i, dsc_dst_i, dsc_len_i, dsc_pat_i,
                        dsc_irq_i, dsc_fence_i};
  assign {h_op, h_src, h_dst, h_len, h_pat, h_irq, h_fence} = head;

  dma_desc_fifo #(.WIDTH(DSC_W), .DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .push_i (dsc_valid_i && !full),
    .data_i (push_data),
    .full_o (full),
    .pop_i  (pop),
    .empty_o(empty),
    .data_o (head)
  );

  dma_wr_tracker #(.CW(OUT_W)) i_trk (
    .clk_i, .rst_ni,
    .wr_i  (mem_wr_o),
    .ack_i (mem_wack_i),
    .idle_o(wr_idle)
  );

  dma_engine #(.AW(AW), .LW(LW), .IW(IW), .MAX_WORDS(MAX_WORDS)) i_eng (
    .clk_i, .rst_ni,
    .dsc_avail_i(!empty),
    .dsc_pop_o  (pop),
    .dsc_op_i   (dma_op_e'(h_op)),
    .dsc_src_i  (h_src),
    .dsc_dst_i  (h_dst),
    .dsc_len_i  (h_len),
    .dsc_pat_i  (h_pat),
    .dsc_irq_i  (h_irq),
    .dsc_fence_i(h_fence),
    .wr_idle_i  (wr_idle),
    .mem_rd_o, .mem_raddr_o, .mem_rdata_i,
    .mem_wr_o, .mem_waddr_o, .mem_wdata_o,
    .done_o, .done_idx_o, .done_err_o, .done_irq_o
  );
endmodule

// File: tb/test_dma_channel.sv
module test_dma_channel;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, LW = 21, IW = 8, MAXW = 16, ACK_LAT = 6;

  logic clk = 0, rst_n = 0;
  logic dsc_valid = 0, dsc_ready;
  logic [1:0] dsc_op = 0;
  logic [AW-1:0] dsc_src = 0, dsc_dst = 0;
  logic [LW-1:0] dsc_len = 0;
  logic [63:0] dsc_pat = 0;
  logic dsc_irq = 0, dsc_fence = 0;
  logic mem_rd, mem_wr, mem_wack = 0;
  logic [AW-1:0] mem_raddr, mem_waddr;
  logic [63:0] mem_rdata = 0, mem_wdata;
  logic done, done_err, done_irq;
  logic [IW-1:0] done_idx;

  dma_channel #(.AW(AW), .LW(LW), .IW(IW), .MAX_WORDS(MAXW)) i_dma_channel (
    .clk_i(clk), .rst_ni(rst_n),
    .dsc_valid_i(dsc_valid), .dsc_ready_o(dsc_ready), .dsc_op_i(dsc_op),
    .dsc_src_i(dsc_src), .dsc_dst_i(dsc_dst), .dsc_len_i(dsc_len),
    .dsc_pat_i(dsc_pat), .dsc_irq_i(dsc_irq), .dsc_fence_i(dsc_fence),
    .mem_rd_o(mem_rd), .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata),
    .mem_wr_o(mem_wr), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .mem_wack_i(mem_wack),
    .done_o(done), .done_idx_o(done_idx), .done_err_o(done_err), .done_irq_o(done_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cycles = 0, outst = 0, exp_idx = 0;
  bit saw_overlap = 0, finished = 0;
  logic [63:0] mem [256];
  logic [63:0] ref_mem [256];
  logic [ACK_LAT-1:0] ack_pipe = '0;

  int rd_addr_q[$], wr_addr_q[$];
  logic [63:0] wr_data_q[$];
  bit rd_fen_q[$], wr_fen_q[$], dn_err_q[$], dn_irq_q[$], dn_fen_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural memory, ack delay line and per-clock comparison, all off the edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cycles++;
      if (mem_rd) begin
        if (rd_addr_q.size() == 0) check(0, "R3 R5 R6 R7 R8", "unexpected read", mem_raddr, 0);
        else begin
          int a; bit f;
          a = rd_addr_q.pop_front(); f = rd_fen_q.pop_front();
          check(mem_raddr == AW'(a), "R3", "read address", mem_raddr, a);
          if (f) check(outst == 0, "R10", "fenced read with writes pending", outst, 0);
          else if (outst != 0) saw_overlap = 1;
        end
        mem_rdata = mem[mem_raddr[7:0]];
      end
      if (mem_wr) begin
        if (wr_addr_q.size() == 0) check(0, "R4 R5 R6 R7 R8", "unexpected write", mem_waddr, 0);
        else begin
          int a; logic [63:0] d; bit f;
          a = wr_addr_q.pop_front(); d = wr_data_q.pop_front(); f = wr_fen_q.pop_front();
          check(mem_waddr == AW'(a), "R3 R4", "write address", mem_waddr, a);
          check(mem_wdata == d, "R3 R4", "write data", mem_wdata, d);
          if (f) check(outst == 0, "R10", "fenced write with writes pending", outst, 0);
        end
        mem[mem_waddr[7:0]] = mem_wdata;
      end
      if (done) begin
        if (dn_err_q.size() == 0) check(0, "R2", "unexpected completion", done_idx, 0);
        else begin
          bit e, q, f;
          e = dn_err_q.pop_front(); q = dn_irq_q.pop_front(); f = dn_fen_q.pop_front();
          check(done_idx == IW'(exp_idx), "R2", "completion index", done_idx, exp_idx);
          check(done_err == e, "R7 R8", "error bit", done_err, e);
          check(done_irq == q, "R9", "irq flag", done_irq, q);
          if (f) check(outst == 0, "R10", "fenced completion with writes pending", outst, 0);
          exp_idx++;
        end
      end
      outst = outst + int'(mem_wr) - int'(mem_wack);
      mem_wack = ack_pipe[ACK_LAT-1];
      ack_pipe = {ack_pipe[ACK_LAT-2:0], mem_wr};
      if (cycles > 5000) begin
        finished = 1;
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic submit(input logic [1:0] op, input int src, input int dst, input int len,
                        input logic [63:0] pat, input bit irq, input bit fence);
    bit pf, err;
    pf = fence;
    err = (op == 2'd3) || (len > MAXW);
    if (!err && op == 2'd1) begin
      for (int i = 0; i < len; i++) begin
        rd_addr_q.push_back(src + i); rd_fen_q.push_back(pf); pf = 0;
        ref_mem[(dst + i) & 255] = ref_mem[(src + i) & 255];
        wr_addr_q.push_back(dst + i); wr_data_q.push_back(ref_mem[(dst + i) & 255]);
        wr_fen_q.push_back(0);
      end
    end else if (!err && op == 2'd2) begin
      for (int i = 0; i < len; i++) begin
        ref_mem[(dst + i) & 255] = pat;
        wr_addr_q.push_back(dst + i); wr_data_q.push_back(pat); wr_fen_q.push_back(pf); pf = 0;
      end
    end
    dn_err_q.push_back(err); dn_irq_q.push_back(irq); dn_fen_q.push_back(pf);
    @(negedge clk);
    while (!dsc_ready) @(negedge clk);
    dsc_op = op; dsc_src = AW'(src); dsc_dst = AW'(dst); dsc_len = LW'(len);
    dsc_pat = pat; dsc_irq = irq; dsc_fence = fence; dsc_valid = 1;
    @(negedge clk);
    dsc_valid = 0;
  endtask

  task automatic drain();
    int n = 0;
    while ((dn_err_q.size() != 0 || outst != 0) && n < 2000) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 64'h5A00_0000_0000_0000 ^ (64'(i) * 64'h0001_0203_0405_0607);
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!mem_rd && !mem_wr && !done, "R1", "idle strobes after reset", {mem_rd, mem_wr, done}, 0);
    check(dsc_ready == 1, "R1", "ready after reset", dsc_ready, 1);

    // R3 copies, second depends on first without a fence (R11 overlap)
    submit(2'd1, 0, 64, 4, 0, 1, 0);
    submit(2'd1, 64, 128, 4, 0, 0, 0);
    // R10 fenced dependent copy
    submit(2'd1, 128, 136, 3, 0, 1, 1);
    // R4 fill
    submit(2'd2, 0, 200, 5, 64'hDEAD_BEEF_0123_4567, 1, 0);
    // R5 null, plain and fenced
    submit(2'd0, 0, 0, 0, 0, 1, 0);
    submit(2'd0, 0, 0, 0, 0, 0, 1);
    // R6 zero-length copy and fill
    submit(2'd1, 10, 90, 0, 0, 1, 0);
    submit(2'd2, 0, 91, 0, 64'h1, 0, 0);
    // R7 length above max rejected, length at max accepted
    submit(2'd1, 0, 160, MAXW + 1, 0, 1, 0);
    submit(2'd2, 0, 20, MAXW, 64'hCAFE_F00D_0000_0001, 0, 0);
    // R8 reserved opcode
    submit(2'd3, 5, 6, 2, 0, 1, 0);
    drain();

    // R12 queue fills while a long fill runs
    submit(2'd2, 0, 40, MAXW, 64'h0F0F_0F0F_F0F0_F0F0, 0, 0);
    for (int k = 0; k < 4; k++) submit(2'd0, 0, 0, 0, 0, k[0], 0);
    check(dsc_ready == 0, "R12", "ready low with full queue", dsc_ready, 0);
    submit(2'd1, 40, 100, 2, 0, 1, 1);
    drain();

    check(dn_err_q.size() == 0, "R2", "completions outstanding", dn_err_q.size(), 0);
    check(rd_addr_q.size() == 0 && wr_addr_q.size() == 0, "R3 R4", "accesses outstanding",
          rd_addr_q.size() + wr_addr_q.size(), 0);
    check(saw_overlap, "R11", "unfenced read overlapped pending write", saw_overlap, 1);
    for (int i = 0; i < 256; i++)
      if (mem[i] !== ref_mem[i]) check(0, "R3 R4", $sformatf("memory word %0d", i), mem[i], ref_mem[i]);
    checks++;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule